// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Cache

This block caches completed address translations for an I/O memory management unit. Each entry belongs to one address space, identified by a 16-bit ASID, and one page, identified by the input address with its in-page offset bits cleared. A client presents an ASID, an input address, a page-size shift and a read/write flag on the lookup port. One clock later the block reports whether the entry was found. On a hit it returns the stored output page and permission bits. A write to a page without write permission raises a fault and returns no translation.

A table walker, which sits outside the block, loads each finished translation through the insert port. The block never evicts single entries. An insert that arrives while the cache is full and does not match a stored key flushes the whole cache, then writes the new entry. Software-driven maintenance uses the invalidate port, which can flush every entry, every entry of one ASID, or the single entry for one ASID and page. Two saturating counters record hits and misses, and a derived output gives the integer hit-rate percentage.

Top module: `tlb_cache`

## Requirements
- R1: A lookup hits only when a valid entry matches both the lookup ASID and the lookup page. A matching page under a different ASID is a miss.
- R2: The lookup, insert and invalidate ports each form a page by clearing the low bits of their address with the mask (1 << shift) - 1, where the shift comes from their granule input. Any address inside the same page therefore finds the same entry.
- R3: rsp_valid and the other response outputs appear in the clock cycle after lk_valid. A lookup issued in the same cycle as an insert or an invalidate sees the contents from before that change.
- R4: The cache holds ENTRIES entries (256 by default). An insert of a new key while all entries are valid first invalidates every entry, then writes the new one.
- R5: Every lookup raises exactly one of two counters: hit_count when the key matches (this includes a faulting write), miss_count otherwise.
- R6: hit_rate equals 100*hit_count/(hit_count+miss_count), using integer division. It is 0 while both counters are zero.
- R7: Both counters saturate at their all-ones value and never wrap.
- R8: Permission bit 1 means write allowed and bit 0 means read allowed. A write lookup that hits an entry whose bit 1 is clear gives rsp_hit=1 and rsp_fault=1, with rsp_page and rsp_perm both zero.
- R9: inv_kind code 0 flushes every entry, code 1 flushes every entry with the given ASID, code 2 flushes the entry matching the ASID and the page, and code 3 does nothing.
- R10: When inv_valid and ins_valid are both high in one cycle, the invalidate takes effect and the insert is dropped.
- R11: Inserting a key that is already present overwrites that entry in place and does not create a second copy.
- R12: After reset no entry is valid, both counters are zero and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Lookup ASID |
| lk_addr | input | ADDR_W | Lookup input address |
| lk_gran | input | GRAN_W | Lookup page-size shift |
| lk_write | input | 1 | Lookup is a write access |
| rsp_valid | output | 1 | Response present (one cycle after lookup) |
| rsp_hit | output | 1 | Key matched |
| rsp_fault | output | 1 | Write to a page without write permission |
| rsp_page | output | ADDR_W | Cached output page |
| rsp_perm | output | PERM_W | Cached permissions (bit1 write, bit0 read) |
| ins_valid | input | 1 | Insert request |
| ins_asid | input | ASID_W | Insert ASID |
| ins_addr | input | ADDR_W | Insert input address |
| ins_gran | input | GRAN_W | Insert page-size shift |
| ins_page | input | ADDR_W | Output page to store |
| ins_perm | input | PERM_W | Permissions to store |
| inv_valid | input | 1 | Invalidate request |
| inv_kind | input | 2 | 0 all, 1 by ASID, 2 by ASID and page, 3 none |
| inv_asid | input | ASID_W | Invalidate ASID |
| inv_addr | input | ADDR_W | Invalidate input address |
| inv_gran | input | GRAN_W | Invalidate page-size shift |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |
| hit_rate | output | 7 | Integer hit percentage |

## Verification
Lookups vary the ASID while the page stays the same, vary the page while the ASID stays the same, and vary the offset inside a page at two page sizes. This separates a key compare that checks both fields from one that checks only one field or ignores the alignment mask. Read and write lookups against a read-only entry show whether the block keeps a matching key apart from a granted access. Inserts and invalidates issued in the same cycle as a lookup or as each other expose the ordering rules. Filling all 256 entries and then adding one more shows the flush-on-full rule against eviction of a single entry. A long run of identical lookups pushes each counter to its saturation limit.

// File: rtl/tlb_cache.sv
module tlb_cache #(
  parameter int ENTRIES = 256,
  parameter int ASID_W  = 16,
  parameter int ADDR_W  = 32,
  parameter int GRAN_W  = 6,
  parameter int PERM_W  = 2,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [GRAN_W-1:0] lk_gran,
  input  logic              lk_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_page,
  output logic [PERM_W-1:0] rsp_perm,
  input  logic              ins_valid,
  input  logic [ASID_W-1:0] ins_asid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [GRAN_W-1:0] ins_gran,
  input  logic [ADDR_W-1:0] ins_page,
  input  logic [PERM_W-1:0] ins_perm,
  input  logic              inv_valid,
  input  logic [1:0]        inv_kind,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic [GRAN_W-1:0] inv_gran,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [6:0]        hit_rate
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int WR_BIT = 1;
  localparam int RW = CNT_W + 8;

  logic [ENTRIES-1:0] vld_q;
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [ADDR_W-1:0]  tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  page_q [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];

  wire [ADDR_W-1:0] lk_tag  = lk_addr  & ({ADDR_W{1'b1}} << lk_gran);
  wire [ADDR_W-1:0] ins_tag = ins_addr & ({ADDR_W{1'b1}} << ins_gran);
  wire [ADDR_W-1:0] inv_tag = inv_addr & ({ADDR_W{1'b1}} << inv_gran);

  logic [ENTRIES-1:0] lk_match, ins_match, inv_sel;
  logic [ADDR_W-1:0]  lk_page;
  logic [PERM_W-1:0]  lk_perm;
  logic [IDX_W-1:0]   match_idx, free_idx, wr_idx;

  always_comb begin
    lk_page = '0;
    lk_perm = '0;
    match_idx = '0;
    free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_match[i]  = vld_q[i] && asid_q[i] == lk_asid && tag_q[i] == lk_tag;
      ins_match[i] = vld_q[i] && asid_q[i] == ins_asid && tag_q[i] == ins_tag;
      case (inv_kind)
        2'd0:    inv_sel[i] = 1'b1;
        2'd1:    inv_sel[i] = asid_q[i] == inv_asid;
        2'd2:    inv_sel[i] = asid_q[i] == inv_asid && tag_q[i] == inv_tag;
        default: inv_sel[i] = 1'b0;
      endcase
      if (lk_match[i]) begin
        lk_page = lk_page | page_q[i];
        lk_perm = lk_perm | perm_q[i];
      end
      if (ins_match[i]) match_idx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld_q[i]) free_idx = IDX_W'(i);
  end

  wire ins_known = |ins_match;
  wire full      = &vld_q;
  wire do_ins    = ins_valid && !inv_valid;
  wire wipe      = do_ins && full && !ins_known;
  assign wr_idx  = ins_known ? match_idx : (full ? '0 : free_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (inv_valid) vld_q <= vld_q & ~inv_sel;
    else if (wipe) vld_q <= ENTRIES'(1);
    else if (do_ins) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_ins) begin
      asid_q[wr_idx] <= ins_asid;
      tag_q[wr_idx]  <= ins_tag;
      page_q[wr_idx] <= ins_page;
      perm_q[wr_idx] <= ins_perm;
    end
  end

  wire lk_hit   = |lk_match;
  wire lk_fault = lk_hit && lk_write && !lk_perm[WR_BIT];
  wire lk_good  = lk_valid && lk_hit && !lk_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_page   <= '0;
      rsp_perm   <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_hit;
      rsp_fault <= lk_valid && lk_fault;
      rsp_page  <= lk_good ? lk_page : '0;
      rsp_perm  <= lk_good ? lk_perm : '0;
      if (lk_valid && lk_hit && hit_count != '1) hit_count <= hit_count + 1'b1;
      if (lk_valid && !lk_hit && miss_count != '1) miss_count <= miss_count + 1'b1;
    end
  end

  logic [RW-1:0] rate_num, rate_den, rate_q;
  always_comb begin
    rate_num = RW'(hit_count) * RW'(100);
    rate_den = RW'(hit_count) + RW'(miss_count);
    rate_q   = (rate_den == '0) ? '0 : rate_num / rate_den;
    hit_rate = rate_q[6:0];
  end

  a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r3_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  a_r5_one_counter: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> $countones({hit_count != $past(hit_count), miss_count != $past(miss_count)}) <= 1);
  a_r5_no_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable(hit_count) && $stable(miss_count));
  a_r6_rate_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rate <= 7'd100);
  a_r6_rate_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count == '0 && miss_count == '0) |-> hit_rate == '0);
  a_r7_hit_sat: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count == '1 |=> hit_count == '1);
  a_r7_miss_sat: assert property (@(posedge clk) disable iff (!rst_n)
    miss_count == '1 |=> miss_count == '1);
  a_r8_fault_no_page: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit && rsp_page == '0 && rsp_perm == '0);
  a_r9_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_kind == 2'd0) |=> vld_q == '0);
  a_r10_inv_wins: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> $countones(vld_q) <= $countones($past(vld_q)));
  a_r11_unique: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
endmodule

// File: tb/tlb_cache_bench.sv
module tlb_cache_bench;
  localparam int CW = 6;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, lk_write = 0;
  logic [15:0] lk_asid = 0;
  logic [31:0] lk_addr = 0;
  logic [5:0]  lk_gran = 0;
  logic rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_page;
  logic [1:0]  rsp_perm;
  logic ins_valid = 0;
  logic [15:0] ins_asid = 0;
  logic [31:0] ins_addr = 0, ins_page = 0;
  logic [5:0]  ins_gran = 0;
  logic [1:0]  ins_perm = 0;
  logic inv_valid = 0;
  logic [1:0]  inv_kind = 0;
  logic [15:0] inv_asid = 0;
  logic [31:0] inv_addr = 0;
  logic [5:0]  inv_gran = 0;
  logic [CW-1:0] hit_count, miss_count;
  logic [6:0] hit_rate;

  int tests = 0, fails = 0;
  int mh = 0, mm = 0;

  always #10 clk = ~clk;

  tlb_cache #(.ENTRIES(256), .CNT_W(CW)) u_tlb_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_addr(lk_addr), .lk_gran(lk_gran), .lk_write(lk_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_page(rsp_page), .rsp_perm(rsp_perm),
    .ins_valid(ins_valid), .ins_asid(ins_asid), .ins_addr(ins_addr), .ins_gran(ins_gran),
    .ins_page(ins_page), .ins_perm(ins_perm),
    .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_asid(inv_asid), .inv_addr(inv_addr), .inv_gran(inv_gran),
    .hit_count(hit_count), .miss_count(miss_count), .hit_rate(hit_rate));

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put_lk(input [15:0] a, input [31:0] ad, input [5:0] g, input w);
    lk_valid = 1; lk_asid = a; lk_addr = ad; lk_gran = g; lk_write = w;
  endtask

  task automatic put_ins(input [15:0] a, input [31:0] ad, input [5:0] g, input [31:0] p, input [1:0] pm);
    ins_valid = 1; ins_asid = a; ins_addr = ad; ins_gran = g; ins_page = p; ins_perm = pm;
  endtask

  task automatic put_inv(input [1:0] k, input [15:0] a, input [31:0] ad, input [5:0] g);
    inv_valid = 1; inv_kind = k; inv_asid = a; inv_addr = ad; inv_gran = g;
  endtask

  task automatic idle_and_step;
    @(negedge clk);
    lk_valid = 0; ins_valid = 0; inv_valid = 0;
  endtask

  task automatic count(input bit h);
    if (h) begin if (mh < MAXC) mh++; end
    else begin if (mm < MAXC) mm++; end
  endtask

  task automatic expect_rsp(string req, bit h, bit f, logic [31:0] p, logic [1:0] pm);
    count(h);
    chk({req, " rsp_valid"}, rsp_valid, 1);
    chk({req, " rsp_hit"}, rsp_hit, h);
    chk({req, " rsp_fault"}, rsp_fault, f);
    chk({req, " rsp_page"}, rsp_page, p);
    chk({req, " rsp_perm"}, rsp_perm, pm);
  endtask

  task automatic lookup(string req, input [15:0] a, input [31:0] ad, input [5:0] g, input w,
                        input bit h, input bit f, input [31:0] p, input [1:0] pm);
    @(negedge clk); put_lk(a, ad, g, w);
    idle_and_step();
    expect_rsp(req, h, f, p, pm);
  endtask

  task automatic insert(input [15:0] a, input [31:0] ad, input [5:0] g, input [31:0] p, input [1:0] pm);
    @(negedge clk); put_ins(a, ad, g, p, pm);
    idle_and_step();
  endtask

  task automatic invalidate(input [1:0] k, input [15:0] a, input [31:0] ad, input [5:0] g);
    @(negedge clk); put_inv(k, a, ad, g);
    idle_and_step();
  endtask

  task automatic check_stats(string req);
    chk({req, " hit_count"}, hit_count, mh);
    chk({req, " miss_count"}, miss_count, mm);
    chk({req, " hit_rate"}, hit_rate, (mh + mm == 0) ? 0 : (100 * mh) / (mh + mm));
  endtask

  task automatic t_reset;
    chk("R12 rsp_valid", rsp_valid, 0);
    chk("R12 hit_count", hit_count, 0);
    chk("R12 miss_count", miss_count, 0);
    chk("R6 zero rate", hit_rate, 0);
    lookup("R12 empty", 16'd5, 32'h1234_5000, 6'd12, 0, 0, 0, 0, 0);
  endtask

  task automatic t_key;
    insert(16'd5, 32'h1234_5000, 6'd12, 32'hABCD_E000, 2'b11);
    lookup("R1 R2 hit offset", 16'd5, 32'h1234_5FFF, 6'd12, 0, 1, 0, 32'hABCD_E000, 2'b11);
    lookup("R1 other asid", 16'd6, 32'h1234_5000, 6'd12, 0, 0, 0, 0, 0);
    lookup("R1 other page", 16'd5, 32'h1234_6000, 6'd12, 0, 0, 0, 0, 0);
    insert(16'd7, 32'h00AB_CDEF, 6'd16, 32'h0055_0000, 2'b01);
    lookup("R2 64k page", 16'd7, 32'h00AB_0001, 6'd16, 0, 1, 0, 32'h0055_0000, 2'b01);
    check_stats("R5 R6 after key");
  endtask

  task automatic t_perm;
    insert(16'd9, 32'h0000_2000, 6'd12, 32'h0009_9000, 2'b01);
    lookup("R8 write readonly", 16'd9, 32'h0000_2010, 6'd12, 1, 1, 1, 0, 0);
    lookup("R8 read readonly", 16'd9, 32'h0000_2010, 6'd12, 0, 1, 0, 32'h0009_9000, 2'b01);
    lookup("R8 write rw", 16'd5, 32'h1234_5000, 6'd12, 1, 1, 0, 32'hABCD_E000, 2'b11);
    check_stats("R5 fault counts hit");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    put_ins(16'd11, 32'h0004_0000, 6'd12, 32'h0044_0000, 2'b11);
    put_lk(16'd11, 32'h0004_0000, 6'd12, 0);
    idle_and_step();
    expect_rsp("R3 lookup sees pre-insert", 0, 0, 0, 0);
    lookup("R3 next cycle hit", 16'd11, 32'h0004_0000, 6'd12, 0, 1, 0, 32'h0044_0000, 2'b11);
    @(negedge clk);
    put_inv(2'd0, 0, 0, 0);
    put_lk(16'd11, 32'h0004_0000, 6'd12, 0);
    idle_and_step();
    expect_rsp("R3 lookup sees pre-invalidate", 1, 0, 32'h0044_0000, 2'b11);
    lookup("R9 all flushed", 16'd11, 32'h0004_0000, 6'd12, 0, 0, 0, 0, 0);
  endtask

  task automatic t_overwrite;
    insert(16'd2, 32'h0000_8000, 6'd12, 32'h0000_1000, 2'b11);
    insert(16'd2, 32'h0000_8000, 6'd12, 32'h0000_2000, 2'b01);
    lookup("R11 new value", 16'd2, 32'h0000_8000, 6'd12, 0, 1, 0, 32'h0000_2000, 2'b01);
    invalidate(2'd2, 16'd2, 32'h0000_8000, 6'd12);
    lookup("R11 no duplicate", 16'd2, 32'h0000_8000, 6'd12, 0, 0, 0, 0, 0);
  endtask

  task automatic t_inv;
    insert(16'd1, 32'h0001_0000, 6'd12, 32'hA000_0000, 2'b11);
    insert(16'd1, 32'h0002_0000, 6'd12, 32'hB000_0000, 2'b11);
    insert(16'd3, 32'h0001_0000, 6'd12, 32'hC000_0000, 2'b11);
    invalidate(2'd1, 16'd1, 0, 6'd12);
    lookup("R9 asid flush A", 16'd1, 32'h0001_0000, 6'd12, 0, 0, 0, 0, 0);
    lookup("R9 asid flush B", 16'd1, 32'h0002_0000, 6'd12, 0, 0, 0, 0, 0);
    lookup("R9 other asid kept", 16'd3, 32'h0001_0000, 6'd12, 0, 1, 0, 32'hC000_0000, 2'b11);
    insert(16'd1, 32'h0001_0000, 6'd12, 32'hA000_0000, 2'b11);
    insert(16'd1, 32'h0002_0000, 6'd12, 32'hB000_0000, 2'b11);
    invalidate(2'd2, 16'd1, 32'h0001_0ABC, 6'd12);
    lookup("R9 page flush gone", 16'd1, 32'h0001_0000, 6'd12, 0, 0, 0, 0, 0);
    lookup("R9 page flush kept", 16'd1, 32'h0002_0000, 6'd12, 0, 1, 0, 32'hB000_0000, 2'b11);
    invalidate(2'd3, 0, 0, 0);
    lookup("R9 code3 no effect", 16'd3, 32'h0001_0000, 6'd12, 0, 1, 0, 32'hC000_0000, 2'b11);
    invalidate(2'd0, 0, 0, 0);
    lookup("R9 flush all", 16'd3, 32'h0001_0000, 6'd12, 0, 0, 0, 0, 0);
  endtask

  task automatic t_priority;
    @(negedge clk);
    put_inv(2'd2, 16'd77, 32'h0700_0000, 6'd12);
    put_ins(16'd8, 32'h0008_0000, 6'd12, 32'h0088_0000, 2'b11);
    idle_and_step();
    lookup("R10 insert dropped", 16'd8, 32'h0008_0000, 6'd12, 0, 0, 0, 0, 0);
  endtask

  task automatic t_full;
    invalidate(2'd0, 0, 0, 0);
    for (int i = 0; i < 256; i++) insert(16'd3, 32'(i) << 12, 6'd12, 32'(i + 1) << 12, 2'b11);
    lookup("R4 first kept", 16'd3, 32'h0000_0000, 6'd12, 0, 1, 0, 32'h0000_1000, 2'b11);
    lookup("R4 last kept", 16'd3, 32'h000F_F000, 6'd12, 0, 1, 0, 32'h0010_0000, 2'b11);
    insert(16'd3, 32'h0000_5000, 6'd12, 32'h0000_F000, 2'b01);
    lookup("R4 R11 overwrite when full", 16'd3, 32'h000F_F000, 6'd12, 0, 1, 0, 32'h0010_0000, 2'b11);
    insert(16'd4, 32'h0000_0000, 6'd12, 32'h0F00_0000, 2'b11);
    lookup("R4 wiped first", 16'd3, 32'h0000_0000, 6'd12, 0, 0, 0, 0, 0);
    lookup("R4 wiped last", 16'd3, 32'h000F_F000, 6'd12, 0, 0, 0, 0, 0);
    lookup("R4 new present", 16'd4, 32'h0000_0000, 6'd12, 0, 1, 0, 32'h0F00_0000, 2'b11);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 70; i++) lookup("R7 miss run", 16'd99, 32'h0, 6'd12, 0, 0, 0, 0, 0);
    check_stats("R7 R6 miss saturated");
    for (int i = 0; i < 70; i++) lookup("R7 hit run", 16'd4, 32'h0, 6'd12, 0, 1, 0, 32'h0F00_0000, 2'b11);
    check_stats("R7 R6 both saturated");
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_key();
    t_perm();
    t_same_cycle();
    t_overwrite();
    t_inv();
    t_priority();
    t_full();
    check_stats("R5 R6 mid run");
    t_saturate();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule